// File: doc/BRIEF.md
# Preloadable Multiply-Accumulate Unit

A clocked datapath that multiplies two signed 18-bit operands each cycle and adds the product to, or subtracts it from, a 52-bit two's-complement accumulator. The direction is chosen per cycle. A load control starts a new accumulation in the same cycle without a dead cycle. It does this by having the feedback multiplexer pass a seed instead of the previous accumulator value. The seed is the 36-bit preload bus placed in the upper bits, with the low 16 bits zero, so a zero preload acts as a clear. To seed all 52 bits, present the low 16 bits as a product, with the second operand equal to one.

The output register shows the accumulator after optional post-processing for Q1.15 operand data. Rounding adds half of the lowest retained weight, 2^14, and then clears bits 14:0. Saturation clamps the value to the signed 31-bit range of a Q1.15 result field and raises a flag. The raw accumulator that feeds back is never rounded or clamped. A signed overflow of the accumulator adder raises a pulse one cycle wide.

Top module: `mac_unit`

## Requirements
- R1: With `add_dir`=1 and `load`=0, the accumulator becomes its old value plus the signed product `op_a*op_b`, visible on `acc_out` one clock edge after the inputs.
- R2: With `add_dir`=0 the product is subtracted instead. The direction may differ on every consecutive cycle.
- R3: With `load`=1 the old accumulator value is ignored. The new value is {`preload`,16'b0} (signed 52-bit) plus or minus the product of that cycle, and accumulation continues from it on the next cycle with no lost cycle. `preload`=0 clears.
- R4: A full 52-bit seed is formed by `load`=1, the upper 36 bits on `preload`, the low 16 bits on `op_a` and `op_b`=1.
- R5: When the accumulator adder overflows the signed 52-bit range (both addends of equal sign, sum of the other sign), the result wraps modulo 2^52 and `ovf_pulse` is 1 on the following cycle.
- R6: When overflow occurs on consecutive cycles, `ovf_pulse` is high only for the first of them. It is never high for two cycles in a row.
- R7: With `rnd_en`=1, `acc_out` equals (accumulator + 2^14) with bits 14:0 cleared, wrapping modulo 2^52. The feedback value is unaffected.
- R8: With `sat_en`=1, a (possibly rounded) value above 2^30-1 is shown as 2^30-1, and one below -2^30 is shown as -2^30, and `sat_hit` is 1. Otherwise `sat_hit` is 0. The feedback value is unaffected.
- R9: Synchronous active-high `rst` clears the accumulator, `acc_out`, `ovf_pulse` and `sat_hit` on the next edge, whatever `load` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 18 | Signed multiplicand |
| op_b | input | 18 | Signed multiplier |
| add_dir | input | 1 | 1 adds the product, 0 subtracts it |
| load | input | 1 | Replace the feedback with the preload seed |
| preload | input | 36 | Upper 36 bits of the seed |
| rnd_en | input | 1 | Round the presented result |
| sat_en | input | 1 | Saturate the presented result |
| acc_out | output | 52 | Registered, post-processed accumulator |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| sat_hit | output | 1 | Presented result was clamped |

## Verification
Some properties are checked by assertions on every cycle. The overflow pulse never lasts two cycles and only follows a detected adder overflow. A clamp shows exactly one of the two limit values and only when saturation was enabled. Rounded output has cleared low bits. A load with a zero product shows the preload seed. Reset clears the outputs. Other behaviour needs the bench's reference model and its scenarios. This covers the exact accumulated values under mixed directions, the no-lost-cycle restart, the full 52-bit seed, the rounding at half values, the clamping at both boundaries, and the suppression of the pulse on the second of two consecutive overflows.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic {
    DIR_SUB = 1'b0,
    DIR_ADD = 1'b1
  } mac_dir_e;

  // per-cycle adder outcome
  typedef struct packed {
    logic wrapped;   // signed overflow of the accumulator adder
    logic neg;       // sign of the wrapped sum
  } add_flags_t;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int A_W = 18,
  parameter int B_W = 18,
  localparam int P_W = A_W + B_W
) (
  input  logic signed [A_W-1:0] a,
  input  logic signed [B_W-1:0] b,
  output logic signed [P_W-1:0] p
);
  always_comb p = P_W'(a) * P_W'(b);
endmodule

// File: rtl/mac_addsub.sv
module mac_addsub
  import mac_pkg::*;
#(
  parameter int ACC_W = 52,
  parameter int P_W   = 36,
  parameter int PRE_W = 36,
  localparam int LOW_W = ACC_W - PRE_W
) (
  input  logic [ACC_W-1:0]       acc_q,
  input  logic signed [P_W-1:0]  prod,
  input  mac_dir_e               dir,
  input  logic                   load,
  input  logic [PRE_W-1:0]       preload,
  output logic [ACC_W-1:0]       sum,
  output add_flags_t             flags
);
  logic [ACC_W-1:0] fb_term;
  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] addend;

  always_comb begin
    fb_term  = load ? {preload, {LOW_W{1'b0}}} : acc_q;
    prod_ext = ACC_W'(prod);
    addend   = (dir == DIR_ADD) ? prod_ext : (~prod_ext + 1'b1);
    sum      = fb_term + addend;
    flags.wrapped = (fb_term[ACC_W-1] == addend[ACC_W-1]) &&
                    (sum[ACC_W-1] != fb_term[ACC_W-1]);
    flags.neg     = sum[ACC_W-1];
  end
endmodule

// File: rtl/mac_post.sv
module mac_post #(
  parameter int ACC_W = 52,
  parameter int RND_W = 15,
  parameter int SAT_W = 31
) (
  input  logic [ACC_W-1:0] val,
  input  logic             rnd_en,
  input  logic             sat_en,
  output logic [ACC_W-1:0] res,
  output logic             clamped
);
  localparam int TOP_W = ACC_W - SAT_W + 1;
  localparam logic [ACC_W-1:0] POS_LIM = {{TOP_W{1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {{TOP_W{1'b1}}, {(SAT_W-1){1'b0}}};

  function automatic logic fits(input logic [ACC_W-1:0] v);
    return (v[ACC_W-1:SAT_W-1] == {TOP_W{1'b0}}) ||
           (v[ACC_W-1:SAT_W-1] == {TOP_W{1'b1}});
  endfunction

  logic [ACC_W-1:0] rounded;

  generate
    if (RND_W > 0) begin : g_rnd
      localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (RND_W - 1);
      logic [ACC_W-1:0] bumped;
      always_comb begin
        bumped  = val + HALF;
        rounded = rnd_en ? {bumped[ACC_W-1:RND_W], {RND_W{1'b0}}} : val;
      end
    end else begin : g_nornd
      always_comb rounded = val;
    end
  endgenerate

  always_comb begin
    clamped = sat_en && !fits(rounded);
    if (clamped) res = rounded[ACC_W-1] ? NEG_LIM : POS_LIM;
    else         res = rounded;
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int A_W   = 18,
  parameter int B_W   = 18,
  parameter int ACC_W = 52,
  parameter int PRE_W = 36,
  parameter int RND_W = 15,
  parameter int SAT_W = 31,
  localparam int P_W  = A_W + B_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [A_W-1:0]   op_a,
  input  logic [B_W-1:0]   op_b,
  input  logic             add_dir,
  input  logic             load,
  input  logic [PRE_W-1:0] preload,
  input  logic             rnd_en,
  input  logic             sat_en,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf_pulse,
  output logic             sat_hit
);
  logic signed [P_W-1:0] prod;
  logic [ACC_W-1:0]      acc_q;
  logic [ACC_W-1:0]      sum;
  add_flags_t            flags;
  logic [ACC_W-1:0]      shown;
  logic                  clamp_now;
  logic                  ovf_evt;
  logic                  evt_q;
  mac_dir_e              dir;

  assign dir     = mac_dir_e'(add_dir);
  assign ovf_evt = flags.wrapped;

  mac_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
    .a(op_a), .b(op_b), .p(prod)
  );

  mac_addsub #(.ACC_W(ACC_W), .P_W(P_W), .PRE_W(PRE_W)) u_add (
    .acc_q(acc_q), .prod(prod), .dir(dir), .load(load),
    .preload(preload), .sum(sum), .flags(flags)
  );

  mac_post #(.ACC_W(ACC_W), .RND_W(RND_W), .SAT_W(SAT_W)) u_post (
    .val(sum), .rnd_en(rnd_en), .sat_en(sat_en),
    .res(shown), .clamped(clamp_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      acc_out   <= '0;
      evt_q     <= 1'b0;
      ovf_pulse <= 1'b0;
      sat_hit   <= 1'b0;
    end else begin
      acc_q     <= sum;
      acc_out   <= shown;
      evt_q     <= ovf_evt;
      ovf_pulse <= ovf_evt && !evt_q;
      sat_hit   <= clamp_now;
    end
  end
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int B_W   = 18,
  parameter int ACC_W = 52,
  parameter int PRE_W = 36,
  parameter int RND_W = 15,
  parameter int SAT_W = 31
) (
  input logic             clk,
  input logic             rst,
  input logic [B_W-1:0]   op_b,
  input logic             load,
  input logic [PRE_W-1:0] preload,
  input logic             rnd_en,
  input logic             sat_en,
  input logic [ACC_W-1:0] acc_out,
  input logic             ovf_pulse,
  input logic             sat_hit,
  input logic             ovf_evt
);
  localparam int TOP_W = ACC_W - SAT_W + 1;
  localparam int LOW_W = ACC_W - PRE_W;
  localparam logic [ACC_W-1:0] POS_LIM = {{TOP_W{1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {{TOP_W{1'b1}}, {(SAT_W-1){1'b0}}};

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> !ovf_pulse); // R6
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> $past(ovf_evt)); // R5
  AST_SAT_ENABLED: assert property (@(posedge clk) disable iff (rst)
    sat_hit |-> $past(sat_en)); // R8
  AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    sat_hit |-> (acc_out == POS_LIM || acc_out == NEG_LIM)); // R8
  AST_ROUND_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(rnd_en) && !sat_hit) |-> acc_out[RND_W-1:0] == '0); // R7
  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
    ($past(load) && $past(op_b) == '0 && !$past(rnd_en) && !$past(sat_en))
      |-> acc_out == {$past(preload), {LOW_W{1'b0}}}); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_out == '0 && !ovf_pulse && !sat_hit)); // R9
endmodule

bind mac_unit mac_unit_chk #(
  .B_W(B_W), .ACC_W(ACC_W), .PRE_W(PRE_W), .RND_W(RND_W), .SAT_W(SAT_W)
) u_chk (
  .clk(clk), .rst(rst), .op_b(op_b), .load(load), .preload(preload),
  .rnd_en(rnd_en), .sat_en(sat_en), .acc_out(acc_out),
  .ovf_pulse(ovf_pulse), .sat_hit(sat_hit), .ovf_evt(ovf_evt)
);

// File: tb/sim_mac_unit.sv
`timescale 1ns/1ps
module sim_mac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] op_a = '0, op_b = '0;
  logic        add_dir = 1'b1, load = 1'b0, rnd_en = 1'b0, sat_en = 1'b0;
  logic [35:0] preload = '0;
  logic [51:0] acc_out;
  logic        ovf_pulse, sat_hit;

  int nchk = 0, nfail = 0;
  longint acc_m = 0;
  bit     prev_evt = 1'b0;
  longint exp_out = 0;
  bit     exp_ovf = 1'b0, exp_sat = 1'b0;

  always #5 clk = ~clk;

  mac_unit u0 (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .add_dir(add_dir),
    .load(load), .preload(preload), .rnd_en(rnd_en), .sat_en(sat_en),
    .acc_out(acc_out), .ovf_pulse(ovf_pulse), .sat_hit(sat_hit)
  );

  function automatic longint wrap52(longint x);
    return (x <<< 12) >>> 12;
  endfunction

  // drive at a falling edge, predict, wait one cycle, compare at the next falling edge
  task automatic step(string tag, bit r, longint a, longint b, bit d, bit ld,
                      longint pre, bit rn, bit sa);
    longint fb, exact, nxt, shown;
    bit evt;
    rst = r; op_a = 18'(a); op_b = 18'(b); add_dir = d; load = ld;
    preload = 36'(pre); rnd_en = rn; sat_en = sa;
    if (r) begin
      acc_m = 0; prev_evt = 0; exp_out = 0; exp_ovf = 0; exp_sat = 0;
    end else begin
      fb    = ld ? (longint'($signed(36'(pre))) <<< 16) : acc_m;
      exact = d ? fb + a * b : fb - a * b;
      nxt   = wrap52(exact);
      evt   = (exact != nxt);
      exp_ovf  = evt && !prev_evt;
      prev_evt = evt;
      acc_m    = nxt;
      shown    = rn ? wrap52((nxt + 16384) & ~64'sd32767) : nxt;
      exp_sat  = 0;
      if (sa && shown > 64'sd1073741823)       begin shown = 64'sd1073741823;  exp_sat = 1; end
      else if (sa && shown < -64'sd1073741824) begin shown = -64'sd1073741824; exp_sat = 1; end
      exp_out = shown;
    end
    @(negedge clk);
    nchk++;
    if (acc_out !== exp_out[51:0] || ovf_pulse !== exp_ovf || sat_hit !== exp_sat) begin
      nfail++;
      $display("FAIL %s: acc=%h ovf=%b sat=%b expected acc=%h ovf=%b sat=%b",
               tag, acc_out, ovf_pulse, sat_hit, exp_out[51:0], exp_ovf, exp_sat);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R9", 1, 0, 0, 1, 0, 0, 0, 0);
    step("R9", 1, 0, 0, 1, 0, 0, 0, 0);
    // R1 accumulate upward
    step("R1", 0, 3, 5, 1, 0, 0, 0, 0);
    step("R1", 0, -7, 100, 1, 0, 0, 0, 0);
    // R2 subtract and alternate every cycle
    step("R2", 0, 10, 10, 0, 0, 0, 0, 0);
    step("R2", 0, -300, 200, 1, 0, 0, 0, 0);
    step("R2", 0, -300, 200, 0, 0, 0, 0, 0);
    step("R2", 0, 131071, -131072, 0, 0, 0, 0, 0);
    // R3 clear by zero seed, then continue without gap
    step("R3", 0, 2, 2, 1, 1, 0, 0, 0);
    step("R3", 0, 1, 1, 1, 0, 0, 0, 0);
    step("R3", 0, 0, 9, 1, 1, 5, 0, 0);
    step("R3", 0, 4, -4, 0, 1, 36'hF_FFFF_FF00, 0, 0);
    step("R3", 0, 7, 7, 1, 0, 0, 0, 0);
    // R4 full 52-bit seed through the multiplier
    step("R4", 0, 43981, 1, 1, 1, 36'h1_2345_6789, 0, 0);
    step("R4", 0, 65535, 1, 1, 1, 36'h8_0000_0001, 0, 0);
    // R7 rounding at half values
    step("R7", 0, 16384, 1, 1, 1, 0, 1, 0);
    step("R7", 0, 16383, 1, 1, 1, 0, 1, 0);
    step("R7", 0, -16384, 1, 1, 1, 0, 1, 0);
    step("R7", 0, -16385, 1, 1, 1, 0, 1, 0);
    step("R7", 0, 0, 0, 1, 0, 0, 0, 0);
    // R8 clamping at both limits
    step("R8", 0, 32768, 32768, 1, 1, 0, 0, 1);
    step("R8", 0, 32767, 32768, 1, 1, 0, 0, 1);
    step("R8", 0, -32768, 32768, 1, 1, 0, 0, 1);
    step("R8", 0, -32769, 32768, 1, 1, 0, 0, 1);
    step("R8", 0, 32767, 32768, 1, 1, 0, 1, 1);
    step("R8", 0, 0, 0, 1, 0, 0, 0, 0);
    // R5 overflow at the top, R6 second consecutive overflow gives no pulse
    step("R5", 0, 0, 0, 1, 1, 36'h7_FFFF_FFFF, 0, 0);
    step("R5", 0, 256, 256, 1, 0, 0, 0, 0);
    step("R6", 0, 256, 256, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 0, 0, 0, 0);
    step("R5", 0, 256, 256, 0, 0, 0, 0, 0);
    // R9 reset wins over load mid-run
    step("R9", 1, 100, 100, 1, 1, 36'h0_0000_0FFF, 1, 1);
    step("R9", 0, 0, 0, 1, 0, 0, 0, 0);
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      longint a = longint'($signed(18'($urandom)));
      longint b = longint'($signed(18'($urandom)));
      bit d = 1'($urandom);
      bit ld = ($urandom % 16) == 0;
      longint pre = longint'({$urandom, $urandom} & 64'hF_FFFF_FFFF);
      bit rn = 1'($urandom);
      bit sa = 1'($urandom);
      step(ld ? "R3" : (sa ? "R8" : (d ? "R1" : "R2")), 0, a, b, d, ld, pre, rn, sa);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule